// File: doc/BRIEF.md
# Duty-Cycled Supply Monitor Controller

This block is the slow-clock digital side of a supply-voltage monitor. It holds the settings for an analog comparator: a 4-bit threshold code, a sampling mode, and enables for reset, wake and interrupt requests. It sends the comparator an enable strobe and the threshold code. It then samples the comparator's "supply below threshold" answer at the end of every enabled period.

The comparator can be left off, kept on continuously, or switched on for a single slow-clock cycle once every 32, 256 or 2048 cycles. Duty cycling cuts the monitor's average power by the same factor. Each measurement refreshes a live flag. A positive measurement (a detection) sets a sticky flag that holds until the status register is read. A detection can also send a one-cycle reset request or wake request to the power controller, each with its own enable. The interrupt line is the sticky flag gated by its enable.

A simple register port is modelled. Writes take effect at the clock edge. Reads are combinational, and a status read clears the sticky flag at the edge that ends the read cycle.

Top module: `supmon_ctrl`

## Requirements
- R1: Bits [3:0] of a write to register select 0 (mode) appear unchanged on `cmp_thresh` from the cycle after the write.
- R2: For sampling-mode codes 2, 3 and 4 (mode bits [6:4]), `cmp_en` is high for exactly one cycle in every 32, 256 or 2048 cycles respectively.
- R3: For sampling-mode code 1, `cmp_en` stays high and a measurement is taken on every clock edge.
- R4: At each clock edge that ends a cycle with `cmp_en` high, the live flag (status bit 0, select 2) takes the value of `cmp_below`.
- R5: A detection (a measurement with `cmp_below` = 1) sets the sticky flag (status bit 1). A read of select 2 returns the value before the clear, then clears the flag at that edge.
- R6: With mode bit 7 set, a detection gives a one-cycle `rst_req` pulse in the cycle after the detecting edge. With the bit clear, no pulse is given.
- R7: With bit 0 of register select 1 (wake) set, a detection gives a one-cycle `wake_req` pulse in the cycle after the detecting edge.
- R8: `irq` is high exactly when the sticky flag is set and mode bit 8 is 1.
- R9: Sampling-mode codes 0, 5, 6 and 7 mean off. When off, `cmp_en` is low, the live flag reads 0 and no detection is recorded.
- R10: A detection at the same edge as a status read leaves the sticky flag set.
- R11: A write to the mode register restarts the sampling period. In a duty-cycled mode, `cmp_en` first rises in the 32nd, 256th or 2048th cycle after the write edge.
- R12: After reset all registers and flags are zero, and `cmp_en`, `rst_req`, `wake_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 mode, 1 wake |
| wr_data | input | 9 | Write data |
| rd_en | input | 1 | Register read strobe (clears sticky on select 2) |
| rd_sel | input | 2 | Read select: 0 mode, 1 wake, 2 status |
| rd_data | output | 9 | Combinational read data |
| cmp_below | input | 1 | Comparator result: supply below threshold |
| cmp_en | output | 1 | Comparator enable strobe |
| cmp_thresh | output | 4 | Threshold code to the comparator |
| rst_req | output | 1 | Core reset request pulse |
| wake_req | output | 1 | Core wake-up request pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cmp_below` is a settled, synchronous level at each slow-clock edge. The analog side is taken to meet that requirement. They also assume that at most one register write happens per cycle. The bench changes every input only on the falling edge. It drives the comparator answer from a deterministic pseudo-random sequence and uses one write strobe. The reference model can therefore take every input as stable at the rising edge.

// File: rtl/supmon_pkg.sv
// Shared encodings for the supply monitor controller.
// Assumes a 2-bit register select and a 9-bit register data path.
package supmon_pkg;
    localparam int THR_W  = 4;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 2;
    localparam int DATA_W = 9;

    // Field positions inside the mode register
    localparam int F_THR  = 0;
    localparam int F_MODE = 4;
    localparam int F_RST  = 7;
    localparam int F_IRQ  = 8;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_WAKE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef enum logic [MODE_W-1:0] {
        SM_OFF   = 3'd0,
        SM_CONT  = 3'd1,
        SM_SHORT = 3'd2,
        SM_MID   = 3'd3,
        SM_LONG  = 3'd4
    } smode_e;
endpackage

// File: rtl/supmon_regs.sv
// Configuration registers of the supply monitor.
// Holds the threshold, the raw sampling-mode code, the reset and irq enables,
// and the wake enable. Flags a mode-register write so the sampler can restart.
// Assumes at most one write per cycle.
module supmon_regs
    import supmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [THR_W-1:0]  thr,
    output logic [MODE_W-1:0] mode,
    output logic              rst_en,
    output logic              irq_en,
    output logic              wake_en,
    output logic              mode_wr
);
    logic wr_mode, wr_wake;

    // Decode which register the write addresses
    always_comb begin
        wr_mode = wr_en && (wr_sel == SEL_MODE);
        wr_wake = wr_en && (wr_sel == SEL_WAKE);
        mode_wr = wr_mode;
    end

    // Mode register fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr    <= '0;
            mode   <= '0;
            rst_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_mode) begin
            thr    <= wr_data[F_THR +: THR_W];
            mode   <= wr_data[F_MODE +: MODE_W];
            rst_en <= wr_data[F_RST];
            irq_en <= wr_data[F_IRQ];
        end
    end

    // Wake register
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_en <= 1'b0;
        else if (wr_wake) wake_en <= wr_data[0];
    end
endmodule

// File: rtl/supmon_sampler.sv
// Sampling-period generator. A free-running counter, cleared by a mode write,
// sets when the comparator is enabled. Duty-cycled modes strobe once per
// 2**LOG_x cycles, continuous mode holds the enable, other codes mean off.
// Assumes LOG_SHORT < LOG_MID < LOG_LONG.
module supmon_sampler
    import supmon_pkg::*;
#(
    parameter int LOG_SHORT = 5,
    parameter int LOG_MID   = 8,
    parameter int LOG_LONG  = 11
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              restart,
    output logic              en,
    output logic              off
);
    localparam int CNT_W = LOG_LONG;

    logic [CNT_W-1:0] cnt_q;

    // Period counter, restarted on every mode write
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // Enable selection per sampling mode
    always_comb begin
        en  = 1'b0;
        off = 1'b0;
        case (mode)
            SM_CONT:  en = 1'b1;
            SM_SHORT: en = &cnt_q[LOG_SHORT-1:0];
            SM_MID:   en = &cnt_q[LOG_MID-1:0];
            SM_LONG:  en = &cnt_q[LOG_LONG-1:0];
            default:  off = 1'b1;
        endcase
    end
endmodule

// File: rtl/supmon_status.sv
// Measurement capture and request generation.
// The live flag follows each measurement, and the sticky flag records
// detections until cleared. A detection wins over a clear in the same cycle.
// Reset and wake requests are one-cycle registered pulses.
module supmon_status (
    input  logic clk,
    input  logic rst_n,
    input  logic meas,
    input  logic off,
    input  logic below,
    input  logic clr,
    input  logic rst_en,
    input  logic wake_en,
    input  logic irq_en,
    output logic live,
    output logic sticky,
    output logic rst_req,
    output logic wake_req,
    output logic irq
);
    logic detect;

    // A detection is a measurement that reports low supply
    always_comb detect = meas && below;

    // Live flag: refreshed on measurement, cleared while off
    always_ff @(posedge clk) begin
        if (!rst_n)    live <= 1'b0;
        else if (meas) live <= below;
        else if (off)  live <= 1'b0;
    end

    // Sticky flag: set by detection, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)      sticky <= 1'b0;
        else if (detect) sticky <= 1'b1;
        else if (clr)    sticky <= 1'b0;
    end

    // Request pulses towards the power controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            rst_req  <= detect && rst_en;
            wake_req <= detect && wake_en;
        end
    end

    // Interrupt: sticky flag gated by its enable
    always_comb irq = sticky && irq_en;
endmodule

// File: rtl/supmon_ctrl.sv
// Top of the supply monitor controller: registers, sampler and status,
// plus the read multiplexer. A read of the status select clears the sticky
// flag at the closing edge. Assumes cmp_below is synchronous to clk.
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int LOG_SHORT = 5,
    parameter int LOG_MID   = 8,
    parameter int LOG_LONG  = 11
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmp_below,
    output logic              cmp_en,
    output logic [THR_W-1:0]  cmp_thresh,
    output logic              rst_req,
    output logic              wake_req,
    output logic              irq
);
    logic [MODE_W-1:0] mode_q;
    logic              rst_en_q, irq_en_q, wake_en_q, mode_wr;
    logic              off, live_q, sticky_q, stat_clr;

    supmon_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .thr(cmp_thresh), .mode(mode_q), .rst_en(rst_en_q), .irq_en(irq_en_q),
        .wake_en(wake_en_q), .mode_wr(mode_wr)
    );

    supmon_sampler #(.LOG_SHORT(LOG_SHORT), .LOG_MID(LOG_MID), .LOG_LONG(LOG_LONG)) u_smp (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .restart(mode_wr), .en(cmp_en), .off(off)
    );

    // Status read strobe
    always_comb stat_clr = rd_en && (rd_sel == SEL_STAT);

    supmon_status u_stat (
        .clk(clk), .rst_n(rst_n), .meas(cmp_en), .off(off), .below(cmp_below),
        .clr(stat_clr), .rst_en(rst_en_q), .wake_en(wake_en_q), .irq_en(irq_en_q),
        .live(live_q), .sticky(sticky_q), .rst_req(rst_req), .wake_req(wake_req), .irq(irq)
    );

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_MODE: begin
                rd_data[F_THR +: THR_W]   = cmp_thresh;
                rd_data[F_MODE +: MODE_W] = mode_q;
                rd_data[F_RST]            = rst_en_q;
                rd_data[F_IRQ]            = irq_en_q;
            end
            SEL_WAKE: rd_data[0] = wake_en_q;
            SEL_STAT: rd_data[1:0] = {sticky_q, live_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/supmon_checker.sv
// Property checker for supmon_ctrl, attached by bind below.
// Assumes cmp_below is a settled synchronous level.
module supmon_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [8:0] wr_data,
    input logic       cmp_below,
    input logic       cmp_en,
    input logic [3:0] cmp_thresh,
    input logic       rst_req,
    input logic       wake_req,
    input logic       irq,
    input logic [2:0] mode,
    input logic       mode_wr,
    input logic       live,
    input logic       sticky,
    input logic       rst_en,
    input logic       wake_en,
    input logic       irq_en
);
    p_thresh_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> cmp_thresh == $past(wr_data[3:0]));

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && mode >= 3'd2 && mode <= 3'd4 && !mode_wr) |=> !cmp_en);

    p_cont_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> cmp_en);

    p_live_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> live == $past(cmp_below));

    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && cmp_below) |=> sticky);

    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(cmp_en && cmp_below && rst_en));

    p_wake_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(cmp_en && cmp_below && wake_en));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sticky && irq_en));

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode > 3'd4) |-> !cmp_en);

    p_off_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 || mode > 3'd4) |=> !live);

    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (!cmp_en || mode == 3'd1));
endmodule

bind supmon_ctrl supmon_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_below(cmp_below), .cmp_en(cmp_en), .cmp_thresh(cmp_thresh),
    .rst_req(rst_req), .wake_req(wake_req), .irq(irq), .mode(mode_q),
    .mode_wr(mode_wr), .live(live_q), .sticky(sticky_q), .rst_en(rst_en_q),
    .wake_en(wake_en_q), .irq_en(irq_en_q)
);

// File: tb/tb_supmon_ctrl.sv
module tb_supmon_ctrl;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [8:0] wr_data = 9'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [8:0] rd_data;
    logic       cmp_below = 1'b0;
    logic       cmp_en;
    logic [3:0] cmp_thresh;
    logic       rst_req, wake_req, irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    supmon_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .cmp_below(cmp_below),
        .cmp_en(cmp_en), .cmp_thresh(cmp_thresh), .rst_req(rst_req),
        .wake_req(wake_req), .irq(irq)
    );

    always #(PER/2) clk = ~clk;

    // Behavioural reference state
    int m_thr, m_mode, m_rsten, m_irqen, m_wake, m_since, m_live, m_sticky, m_rst, m_wk;

    function automatic int period_of(int md);
        case (md)
            2: return 32;
            3: return 256;
            4: return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_en();
        if (m_mode == 1) return 1;
        if (period_of(m_mode) == 0) return 0;
        return ((m_since % period_of(m_mode)) == period_of(m_mode) - 1) ? 1 : 0;
    endfunction

    function automatic int exp_rd(int sel);
        case (sel)
            0: return (m_irqen << 8) | (m_rsten << 7) | (m_mode << 4) | m_thr;
            1: return m_wake;
            2: return (m_sticky << 1) | m_live;
            default: return 0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_thr = 0; m_mode = 0; m_rsten = 0; m_irqen = 0; m_wake = 0;
            m_since = 0; m_live = 0; m_sticky = 0; m_rst = 0; m_wk = 0;
        end else begin
            int meas;
            int det;
            meas = exp_en();
            det  = meas & int'(cmp_below);
            if (meas != 0) m_live = int'(cmp_below);
            else if (period_of(m_mode) == 0 && m_mode != 1) m_live = 0;
            if (det != 0) m_sticky = 1;
            else if (rd_en && rd_sel == 2'd2) m_sticky = 0;
            m_rst = det & m_rsten;
            m_wk  = det & m_wake;
            if (wr_en && wr_sel == 2'd0) begin
                m_thr = int'(wr_data[3:0]); m_mode = int'(wr_data[6:4]);
                m_rsten = int'(wr_data[7]); m_irqen = int'(wr_data[8]);
                m_since = 0;
            end else begin
                m_since = (m_since + 1) % 2048;
            end
            if (wr_en && wr_sel == 2'd1) m_wake = int'(wr_data[0]);
        end
    end

    // Cycle-by-cycle comparison, a quarter period after the rising edge
    always @(posedge clk) begin
        cyc++;
        #(PER/4);
        if (rst_n && !done) begin
            chk(int'(cmp_thresh) == m_thr, "R1", int'(cmp_thresh), m_thr);
            chk(int'(cmp_en) == exp_en(), "R2", int'(cmp_en), exp_en());
            chk(int'(rst_req) == m_rst, "R6", int'(rst_req), m_rst);
            chk(int'(wake_req) == m_wk, "R7", int'(wake_req), m_wk);
            chk(int'(irq) == (m_sticky & m_irqen), "R8", int'(irq), m_sticky & m_irqen);
            chk(int'(rd_data) == exp_rd(int'(rd_sel)), "R5", int'(rd_data), exp_rd(int'(rd_sel)));
        end
    end

    task automatic wr(logic [1:0] sel, logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a one-cycle status read, return the combinational data
    task automatic rd_stat(output logic [8:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 2'd2;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_sel = 2'd0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [8:0] mreg(bit irqe, bit rste, int md, int th);
        return {irqe, rste, 3'(md), 4'(th)};
    endfunction

    initial begin
        logic [8:0] v;
        logic [15:0] lfsr = 16'hACE1;
        int hits;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!cmp_en && !rst_req && !wake_req && !irq && cmp_thresh == 0, "R12",
            int'({cmp_en, rst_req, wake_req, irq}), 0);
        rd_sel = 2'd2; #1;
        chk(rd_data == 0, "R12", int'(rd_data), 0);
        rd_sel = 2'd0;
        rst_n = 1'b1;

        // R11 and R2: first strobe 32 cycles after the write edge
        wr(2'd1, 9'd1);
        cmp_below = 1'b1;
        wr(2'd0, mreg(1, 1, 2, 10));
        hits = 0;
        for (int i = 0; i < 32; i++) begin
            chk(cmp_en == (i == 31), "R11", int'(cmp_en), int'(i == 31));
            if (cmp_en) hits++;
            if (i < 31) @(negedge clk);
        end
        chk(hits == 1, "R2", hits, 1);
        idle(3);
        // R4, R5: detection recorded, read clears sticky
        rd_stat(v);
        chk(v[1:0] == 2'b11, "R5", int'(v[1:0]), 3);
        rd_stat(v);
        chk(v[1:0] == 2'b01, "R5", int'(v[1:0]), 1);
        chk(irq == 1'b0, "R8", int'(irq), 0);
        cmp_below = 1'b0;
        idle(34);
        rd_stat(v);
        chk(v[0] == 1'b0, "R4", int'(v[0]), 0);

        // R3: continuous mode, live tracks every cycle
        wr(2'd0, mreg(0, 0, 1, 3));
        chk(cmp_en == 1'b1, "R3", int'(cmp_en), 1);
        cmp_below = 1'b1;
        @(negedge clk);
        rd_stat(v);
        chk(v[0] == 1'b1, "R3", int'(v[0]), 1);
        // R10: detection at the same edge as the read keeps sticky set
        rd_stat(v);
        chk(v[1] == 1'b1, "R10", int'(v[1]), 1);
        cmp_below = 1'b0;
        @(negedge clk);
        rd_stat(v);
        chk(v[0] == 1'b0, "R3", int'(v[0]), 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cmp_below = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        // R9: off codes hold the comparator down and record nothing
        wr(2'd0, mreg(1, 1, 6, 5));
        cmp_below = 1'b1;
        rd_stat(v);
        idle(50);
        chk(cmp_en == 1'b0, "R9", int'(cmp_en), 0);
        rd_stat(v);
        chk(v[1:0] == 2'b00, "R9", int'(v[1:0]), 0);
        wr(2'd0, mreg(1, 1, 0, 5));
        idle(40);
        rd_stat(v);
        chk(v[1:0] == 2'b00, "R9", int'(v[1:0]), 0);
        chk(rst_req == 1'b0 && irq == 1'b0, "R9", int'({rst_req, irq}), 0);

        // R2, R6, R7: long periods with pseudo-random comparator answers
        wr(2'd1, 9'd0);
        wr(2'd0, mreg(1, 0, 3, 15));
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            cmp_below = lfsr[0];
            rd_en = (lfsr[5:3] == 3'd0); rd_sel = lfsr[7:6];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        rd_en = 1'b0;
        wr(2'd1, 9'd1);
        wr(2'd0, mreg(0, 1, 4, 7));
        cmp_below = 1'b1;
        for (int i = 0; i < 4200; i++) begin
            @(negedge clk);
            if (i > 2100) cmp_below = lfsr[0];
            rd_en = (lfsr[6:3] == 4'd0); rd_sel = lfsr[8:7];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
        rd_en = 1'b0;
        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule